// File: doc/BRIEF.md
# Programmable Row Delay Line for a 3x3 Window

This block is the pixel-input front end of a 3x3 image convolver. It takes one pixel per clock, qualified by a valid strobe, and delays it through zero to three optional register stages. It then passes it through two cascaded circular row buffers, each as long as one image row. The current pixel and its two row-delayed copies are each kept for three accepted pixels, so nine pixels from a 3x3 neighbourhood of the image are presented at once. A downstream multiplier array reads them as positions A to I.

The row length is written once after reset through a small load port. The code spans 1 to 1023, and code 0 stands for 1024. If no length is written within a fixed window of clock cycles after reset, the length stays at 1024 and the port is closed until the next reset. A length of 3 turns the nine taps into one continuous nine-sample line. Lengths of 1 and 2 give no useful image window, but the buffers still run correctly. In external cascade mode the two delayed rows come from input pins instead of the internal buffers, so several devices can share one set of row memories.

Top module: `row_window_gen`

## Requirements
- R1: After reset the row length is 1024. A written code c in 1..1023 gives a row length of c, and code 0 gives 1024.
- R2: Only the first write to `len_code` after reset takes effect. Later writes leave the row length unchanged until the next reset.
- R3: A write is only accepted within the first LOAD_WIN (1024) clock edges after reset. After that, writes are ignored and the length stays 1024.
- R4: `pre_sel` (0..3) sets how many clock cycles pass between an input pixel being sampled and it being accepted into the window path.
- R5: Count accepted pixels as x[1], x[2], ... and let n be the count so far. In internal mode, with row length L, the tap at row rr and column cc (rr=0 oldest row, cc=0 oldest column) holds x[n-(2-cc)-L*(2-rr)]. It sits at position p=3*rr+cc, on `win_out[8p+7:8p]`.
- R6: Row lengths 1 and 2 follow the same tap formula as R5.
- R7: With row length 3, position p holds x[n-8+p], giving nine consecutive samples.
- R8: With `casc_ext`=1, rows rr=1 and rr=0 take the values of `ext_rows[7:0]` and `ext_rows[15:8]` that were sampled with each pixel. Row rr=2 still takes the pixel itself. All rows use the same column delays as in R5.
- R9: The window changes only on a clock edge at which a pixel is accepted.
- R10: `win_valid` is low after reset. It rises on the acceptance that brings n to 2L+3 (internal mode) or 3 (external mode), and stays high until reset.
- R11: While in reset and just after it, `win_out` is all zero and `win_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| len_we | input | 1 | Row length write strobe |
| len_code | input | 10 | Row length code, 0 means 1024 |
| pre_sel | input | 2 | Number of pre-delay stages |
| casc_ext | input | 1 | 1 selects external row inputs |
| pix_valid | input | 1 | Input pixel valid |
| pix_in | input | 8 | Input pixel |
| ext_rows | input | 16 | External one-row-back [7:0] and two-rows-back [15:8] pixels |
| win_out | output | 72 | Nine window taps, position p at bits 8p+7:8p |
| win_valid | output | 1 | All nine taps hold accepted pixels |

## Verification
The assertions assume several things about the inputs. `pre_sel` and `casc_ext` are held constant between resets. `pix_valid` is low while reset is asserted. The row length is settled before the first pixel arrives, because the buffer pointers take it as fixed. The bench sets the configuration only inside its reset sequence, writes the length before streaming, and drives pixels with random gaps. It also includes a run where the load window is allowed to expire before a late write.

// File: rtl/rwd_pkg.sv
package rwd_pkg;

  // Number of accepted pixels needed before every tap of a k x k window
  // holds real data.
  function automatic int unsigned fill_target(input int unsigned len,
                                              input int unsigned k,
                                              input bit ext);
    if (ext) return k;
    return (k - 1) * len + k;
  endfunction

endpackage

// File: rtl/rwd_cfg.sv
module rwd_cfg #(
  parameter int MAX_LEN  = 1024,
  parameter int LOAD_WIN = 1024,
  localparam int CW = $clog2(MAX_LEN),
  localparam int LW = $clog2(MAX_LEN + 1),
  localparam int TW = $clog2(LOAD_WIN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          len_we,
  input  logic [CW-1:0] len_code,
  output logic [LW-1:0] row_len,
  output logic          locked
);

  logic [TW-1:0] tmr;

  // Write-once length register with a load window that closes by itself
  always_ff @(posedge clk) begin
    if (rst) begin
      tmr     <= '0;
      locked  <= 1'b0;
      row_len <= LW'(MAX_LEN);
    end else if (!locked) begin
      tmr <= tmr + 1'b1;
      if (len_we) begin
        locked  <= 1'b1;
        row_len <= (len_code == '0) ? LW'(MAX_LEN) : LW'(len_code);
      end else if (tmr == TW'(LOAD_WIN - 1)) begin
        locked <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rwd_predelay.sv
module rwd_predelay #(
  parameter int W    = 24,
  parameter int MAXD = 3,
  localparam int SW = $clog2(MAXD + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] sel,
  input  logic          in_v,
  input  logic [W-1:0]  in_d,
  output logic          out_v,
  output logic [W-1:0]  out_d
);

  logic         v_pipe [1:MAXD];
  logic [W-1:0] d_pipe [1:MAXD];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 1; i <= MAXD; i++) v_pipe[i] <= 1'b0;
    end else begin
      v_pipe[1] <= in_v;
      for (int i = 2; i <= MAXD; i++) v_pipe[i] <= v_pipe[i-1];
    end
  end

  // Data stages carry no reset; only the strobe needs a known value
  always_ff @(posedge clk) begin
    d_pipe[1] <= in_d;
    for (int i = 2; i <= MAXD; i++) d_pipe[i] <= d_pipe[i-1];
  end

  always_comb begin
    out_v = in_v;
    out_d = in_d;
    for (int i = 1; i <= MAXD; i++) begin
      if (int'(sel) == i) begin
        out_v = v_pipe[i];
        out_d = d_pipe[i];
      end
    end
  end

endmodule

// File: rtl/rwd_ring.sv
module rwd_ring #(
  parameter int W     = 8,
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [LW-1:0] len,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] ptr;
  logic          bypass;

  assign bypass = (len == '0);

  // Plain write port so the array maps to block RAM
  always_ff @(posedge clk) begin
    if (en && !bypass) mem[ptr] <= din;
  end

  // Read-first output register and circular pointer
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= '0;
      dout <= '0;
    end else if (en) begin
      if (bypass) begin
        dout <= din;
      end else begin
        dout <= mem[ptr];
        ptr  <= (LW'(ptr) == len - 1'b1) ? '0 : ptr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rwd_window.sv
module rwd_window #(
  parameter int W    = 8,
  parameter int K    = 3,
  parameter int CNTW = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  logic             ext_mode,
  input  logic [W-1:0]     pix,
  input  logic [(K-1)*W-1:0] ext_rows,
  input  logic [(K-1)*W-1:0] buf_rows,
  input  logic [CNTW-1:0]  thr,
  output logic [K*K*W-1:0] win,
  output logic             win_valid
);

  logic [W-1:0]    q0;
  logic [W-1:0]    extq [1:K-1];
  logic [W-1:0]    sh   [1:K-1][K];
  logic [W-1:0]    tap  [K][K];
  logic [CNTW-1:0] cnt;

  // Newest column: row 0 is the pixel, deeper rows come from buffers or pins
  always_ff @(posedge clk) begin
    if (rst) begin
      q0 <= '0;
      for (int r = 1; r < K; r++) extq[r] <= '0;
    end else if (acc) begin
      q0 <= pix;
      for (int r = 1; r < K; r++) extq[r] <= ext_rows[(r-1)*W +: W];
    end
  end

  always_comb begin
    tap[0][0] = q0;
    for (int r = 1; r < K; r++)
      tap[0][r] = ext_mode ? extq[r] : buf_rows[(r-1)*W +: W];
    for (int c = 1; c < K; c++)
      for (int r = 0; r < K; r++)
        tap[c][r] = sh[c][r];
  end

  // Older columns shift once per accepted pixel
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 1; c < K; c++)
        for (int r = 0; r < K; r++) sh[c][r] <= '0;
    end else if (acc) begin
      for (int c = 1; c < K; c++)
        for (int r = 0; r < K; r++) sh[c][r] <= tap[c-1][r];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      win_valid <= 1'b0;
    end else if (acc) begin
      if (cnt != '1) cnt <= cnt + 1'b1;
      if (({1'b0, cnt} + 1'b1) >= {1'b0, thr}) win_valid <= 1'b1;
    end
  end

  // Position p = rr*K + cc, rr=0 oldest row, cc=0 oldest column
  always_comb begin
    for (int rr = 0; rr < K; rr++)
      for (int cc = 0; cc < K; cc++)
        win[(rr*K + cc)*W +: W] = tap[K-1-cc][K-1-rr];
  end

endmodule

// File: rtl/row_window_gen.sv
module row_window_gen #(
  parameter int PIX_W    = 8,
  parameter int MAX_LEN  = 1024,
  parameter int K        = 3,
  parameter int MAXPRE   = 3,
  parameter int LOAD_WIN = 1024,
  localparam int CW   = $clog2(MAX_LEN),
  localparam int LW   = $clog2(MAX_LEN + 1),
  localparam int SW   = $clog2(MAXPRE + 1),
  localparam int NR   = K - 1,
  localparam int CNTW = $clog2(NR*MAX_LEN + K + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 len_we,
  input  logic [CW-1:0]        len_code,
  input  logic [SW-1:0]        pre_sel,
  input  logic                 casc_ext,
  input  logic                 pix_valid,
  input  logic [PIX_W-1:0]     pix_in,
  input  logic [NR*PIX_W-1:0]  ext_rows,
  output logic [K*K*PIX_W-1:0] win_out,
  output logic                 win_valid
);

  logic [LW-1:0]        row_len;
  logic                 cfg_locked;
  logic                 pix_acc;
  logic [K*PIX_W-1:0]   acc_bus;
  logic [PIX_W-1:0]     acc_pix;
  logic [NR*PIX_W-1:0]  acc_ext;
  logic [NR*PIX_W-1:0]  buf_out;
  logic [CNTW-1:0]      fill_thr;

  rwd_cfg #(.MAX_LEN(MAX_LEN), .LOAD_WIN(LOAD_WIN)) u_cfg (
    .clk(clk), .rst(rst), .len_we(len_we), .len_code(len_code),
    .row_len(row_len), .locked(cfg_locked)
  );

  rwd_predelay #(.W(K*PIX_W), .MAXD(MAXPRE)) u_pre (
    .clk(clk), .rst(rst), .sel(pre_sel), .in_v(pix_valid),
    .in_d({ext_rows, pix_in}), .out_v(pix_acc), .out_d(acc_bus)
  );

  assign acc_pix = acc_bus[PIX_W-1:0];
  assign acc_ext = acc_bus[K*PIX_W-1:PIX_W];

  // First ring is a full row; later rings are fed from a registered
  // output, so each is one entry shorter to stay column-aligned.
  generate
    for (genvar i = 0; i < NR; i++) begin : g_row
      logic [PIX_W-1:0] b_din;
      logic [LW-1:0]    b_len;
      if (i == 0) begin : g_first
        assign b_din = acc_pix;
        assign b_len = row_len;
      end else begin : g_next
        assign b_din = buf_out[(i-1)*PIX_W +: PIX_W];
        assign b_len = row_len - 1'b1;
      end
      rwd_ring #(.W(PIX_W), .DEPTH(MAX_LEN)) u_ring (
        .clk(clk), .rst(rst), .en(pix_acc), .len(b_len),
        .din(b_din), .dout(buf_out[i*PIX_W +: PIX_W])
      );
    end
  endgenerate

  assign fill_thr = CNTW'(rwd_pkg::fill_target(32'(row_len), K, casc_ext));

  rwd_window #(.W(PIX_W), .K(K), .CNTW(CNTW)) u_win (
    .clk(clk), .rst(rst), .acc(pix_acc), .ext_mode(casc_ext),
    .pix(acc_pix), .ext_rows(acc_ext), .buf_rows(buf_out),
    .thr(fill_thr), .win(win_out), .win_valid(win_valid)
  );

endmodule

// File: rtl/rwd_chk.sv
module rwd_chk #(
  parameter int PIX_W   = 8,
  parameter int K       = 3,
  parameter int MAX_LEN = 1024,
  parameter int MAXPRE  = 3,
  localparam int LW = $clog2(MAX_LEN + 1),
  localparam int SW = $clog2(MAXPRE + 1)
) (
  input logic                 clk,
  input logic                 rst,
  input logic [SW-1:0]        pre_sel,
  input logic                 pix_valid,
  input logic                 acc,
  input logic                 cfg_locked,
  input logic [LW-1:0]        row_len,
  input logic [K*K*PIX_W-1:0] win_out,
  input logic                 win_valid
);

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  // R1
  len_default_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_locked |-> row_len == LW'(MAX_LEN));

  // R2
  len_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_locked |=> $stable(row_len));

  // R4
  pre_one_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(pre_sel) == 1 && age >= 2'd1) |-> acc == $past(pix_valid));

  // R4
  pre_two_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(pre_sel) == 2 && age >= 2'd2) |-> acc == $past(pix_valid, 2));

  // R4
  pre_three_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(pre_sel) == 3 && age == 2'd3) |-> acc == $past(pix_valid, 3));

  // R9
  win_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(win_out));

  // R10
  valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    win_valid |=> win_valid);

  // R10
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(win_valid) |-> $past(acc));

  generate
    for (genvar rr = 0; rr < K; rr++) begin : g_r
      for (genvar cc = 0; cc < K - 1; cc++) begin : g_c
        // R5
        col_shift_chk: assert property (@(posedge clk) disable iff (rst)
          acc |=> win_out[(rr*K+cc)*PIX_W +: PIX_W] ==
                  $past(win_out[(rr*K+cc+1)*PIX_W +: PIX_W]));
      end
    end
  endgenerate

endmodule

bind row_window_gen rwd_chk #(
  .PIX_W(PIX_W), .K(K), .MAX_LEN(MAX_LEN), .MAXPRE(MAXPRE)
) u_chk (
  .clk(clk), .rst(rst), .pre_sel(pre_sel), .pix_valid(pix_valid),
  .acc(pix_acc), .cfg_locked(cfg_locked), .row_len(row_len),
  .win_out(win_out), .win_valid(win_valid)
);

// File: tb/tb_row_window_gen.sv
module tb_row_window_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WIN_CYC    = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        len_we = 1'b0;
  logic [9:0]  len_code = '0;
  logic [1:0]  pre_sel = '0;
  logic        casc_ext = 1'b0;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_in = '0;
  logic [15:0] ext_rows = '0;
  wire  [71:0] win_out;
  wire         win_valid;

  row_window_gen dut (
    .clk(clk), .rst(rst), .len_we(len_we), .len_code(len_code),
    .pre_sel(pre_sel), .casc_ext(casc_ext), .pix_valid(pix_valid),
    .pix_in(pix_in), .ext_rows(ext_rows), .win_out(win_out),
    .win_valid(win_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int L, d, np, nacc;
  bit ext;
  bit [3:0] vq;
  string cur_tag;
  logic [7:0] hx [0:4095];
  logic [7:0] h1 [0:4095];
  logic [7:0] h2 [0:4095];
  logic [71:0] prev_win;

  function automatic int fill_need();
    return ext ? 3 : 2*L + 3;
  endfunction

  task automatic check_window(input bit accepted);
    bit ev;
    logic [71:0] expv;
    ev = (nacc >= fill_need());
    n_tests++;
    if (win_valid !== ev) begin
      n_fail++;
      $display("FAIL R10 win_valid after %0d accepted: got %0b exp %0b", nacc, win_valid, ev);
    end
    if (!accepted) begin
      n_tests++;
      if (win_out !== prev_win) begin
        n_fail++;
        $display("FAIL R9 window moved without accept: got %h exp %h", win_out, prev_win);
      end
    end
    if (ev) begin
      for (int p = 0; p < 9; p++) begin
        int rr, cc, base;
        rr = p / 3; cc = p % 3;
        base = nacc - (2 - cc);
        if (ext) expv[p*8 +: 8] = (rr == 2) ? hx[base] : (rr == 1) ? h1[base] : h2[base];
        else     expv[p*8 +: 8] = hx[base - L*(2 - rr)];
      end
      n_tests++;
      if (win_out !== expv) begin
        n_fail++;
        $display("FAIL %s window (L=%0d, pre-delay %0d, R4) n=%0d: got %h exp %h",
                 cur_tag, L, d, nacc, win_out, expv);
      end
    end
  endtask

  task automatic step(input bit v);
    @(negedge clk);
    pix_valid = v;
    pix_in    = 8'($urandom);
    ext_rows  = 16'($urandom);
    if (v) begin
      np++;
      hx[np] = pix_in; h1[np] = ext_rows[7:0]; h2[np] = ext_rows[15:8];
    end
    prev_win = win_out;
    @(posedge clk); #1;
    vq = {vq[2:0], v};
    if (vq[d]) nacc++;
    check_window(vq[d]);
  endtask

  task automatic do_reset(input int sel, input bit e);
    @(negedge clk);
    rst = 1'b1; pix_valid = 1'b0; len_we = 1'b0;
    pre_sel = 2'(sel); casc_ext = e;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    np = 0; nacc = 0; vq = '0; d = sel; ext = e;
    // R11 reset state
    n_tests++;
    if (win_valid !== 1'b0 || win_out !== '0) begin
      n_fail++;
      $display("FAIL R11 reset state: got valid=%0b win=%h exp valid=0 win=0", win_valid, win_out);
    end
  endtask

  task automatic load(input int code);
    @(negedge clk);
    len_we = 1'b1; len_code = 10'(code);
    @(negedge clk);
    len_we = 1'b0;
  endtask

  task automatic stream(input int extra);
    while (nacc < fill_need() + extra) step($urandom_range(0, 3) != 0);
    repeat (4) step(1'b0);
  endtask

  task automatic run_cfg(input int code, input int sel, input bit e, input string tag);
    do_reset(sel, e);
    load(code);
    L = (code == 0) ? 1024 : code;
    cur_tag = tag;
    stream(40);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R5: ordinary row length, no pre-delay
    run_cfg(5, 0, 1'b0, "R5");
    // R6: degenerate row lengths
    run_cfg(1, 1, 1'b0, "R6");
    run_cfg(2, 2, 1'b0, "R6");
    // R7: length 3 forms a nine-tap line
    run_cfg(3, 3, 1'b0, "R7");
    // R8: external rows
    run_cfg(6, 2, 1'b1, "R8");
    run_cfg(4, 0, 1'b1, "R8");
    // R2: second write is ignored, window must follow L=4
    do_reset(1, 1'b0);
    load(4);
    load(7);
    L = 4; cur_tag = "R2";
    stream(30);
    // R1: explicit code 0 means 1024
    run_cfg(0, 1, 1'b0, "R1");
    // R3: load window expires, late write of 5 ignored, L stays 1024
    do_reset(0, 1'b0);
    L = 1024; cur_tag = "R3";
    repeat (WIN_CYC + 4) step(1'b0);
    load(5);
    stream(20);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule